// File: doc/BRIEF.md
# ADC Result Buffer with Channel Injection

This block sits between an ADC conversion engine and the CPU's register interface. It holds two result registers: one for ordinary conversions and one for injected conversions, each with its own valid flag, read strobe and one-cycle interrupt pulse. When the engine delivers a result whose target register is still unread, the result is parked in a single shared holding slot. The slot takes either kind of result. While the slot is occupied, a suspend output tells the engine to hold off further conversions.

When the CPU reads a result register that has a matching result parked in the slot, the parked value moves in. The matching interrupt then fires again, so software always learns that fresh data has arrived and the buffer can never lock up. Injection requests from the system are passed to the engine as a single-cycle start pulse. This pulse is issued only while the hold-for-read mode is on and the buffer is not suspended. Turning the hold-for-read mode off empties the slot and releases a suspended engine.

Top module: `adc_result_buffer`

## Requirements
- R1: After reset, every output is low or zero: both valid flags, both interrupts, both result registers, suspend and the injection start pulse.
- R2: With the ordinary register free, an ordinary conversion (`cnv_done`=1, `cnv_inj`=0) is stored in `std_data`. `std_valid` and a one-cycle `std_irq` follow on the next clock edge.
- R3: With the injected register free and hold-for-read on, an injected conversion (`cnv_inj`=1) is stored in `inj_data` with `inj_valid` and a one-cycle `inj_irq` on the next edge. `std_data` is left unchanged.
- R4: With hold-for-read off (`hold_mode`=0), injected conversions are discarded: `inj_irq` stays low and `inj_data` is unchanged.
- R5: With hold-for-read on, a conversion whose target register is valid and not read in that cycle is parked. `suspend` is high from the next edge, no interrupt fires, and the target register keeps its old value.
- R6: A read of the injected register (`rd_inj`) while an injected result is parked loads that result into `inj_data`, raises `inj_irq` again and drops `suspend`, all on the next edge.
- R7: A read of the ordinary register (`rd_std`) while an ordinary result is parked loads it into `std_data`, raises `std_irq` and drops `suspend` on the next edge.
- R8: A conversion that arrives in the same cycle as a read of its target register, with nothing parked for that register, is written straight into the register. `suspend` stays low.
- R9: While `hold_mode` is low, the holding slot is emptied and `suspend` is low from the next edge. A result parked before that is never delivered.
- R10: A one-cycle `inj_req` with hold-for-read on gives a one-cycle `inj_start` two edges later if not suspended. While suspended, the start waits until the edge after suspend falls. A request made with hold-for-read off is dropped.
- R11: A read strobe clears its register's valid flag on the next edge, unless a new result is written there at that edge.
- R12: With hold-for-read off, each ordinary conversion overwrites `std_data` and raises `std_irq` even if unread, and `suspend` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hold_mode | input | 1 | Hold-for-read mode enable |
| cnv_done | input | 1 | Conversion-complete pulse from the engine |
| cnv_inj | input | 1 | Tag of the completing conversion: 1 = injected |
| cnv_data | input | DW | Conversion result |
| inj_req | input | 1 | Injection request pulse |
| rd_std | input | 1 | CPU read strobe of the ordinary result register |
| rd_inj | input | 1 | CPU read strobe of the injected result register |
| std_data | output | DW | Ordinary result register |
| std_valid | output | 1 | Ordinary result unread |
| std_irq | output | 1 | Ordinary conversion-complete interrupt pulse |
| inj_data | output | DW | Injected result register |
| inj_valid | output | 1 | Injected result unread |
| inj_irq | output | 1 | Injection-complete interrupt pulse |
| suspend | output | 1 | Holding slot occupied; engine must wait |
| inj_start | output | 1 | Start pulse for an injected conversion |

## Verification
Every result register, valid flag, interrupt and the suspend flag is registered once, so each responds at the first clock edge after the cycle that carries the stimulus. The injection start pulse passes through a pending flag and so arrives one edge later. The bench applies each stimulus for exactly one cycle on a falling edge. It compares outputs on the following falling edge, which is one rising edge later. For the injection start it waits one extra idle cycle before comparing. Interrupt pulse width is confirmed with a further idle cycle, which must show the interrupt low again.

// File: rtl/adcb_pkg.sv
package adcb_pkg;
  // A result register can take a new value this cycle if empty or being read now.
  function automatic logic slot_free(input logic valid, input logic rd);
    return !valid || rd;
  endfunction

  // The parked result leaves the slot when its own register is read.
  function automatic logic hold_drains(input logic full, input logic is_inj,
                                       input logic rd_s, input logic rd_i);
    return full && (is_inj ? rd_i : rd_s);
  endfunction
endpackage

// File: rtl/adcb_slot.sv
module adcb_slot #(
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd,
  input  logic          wr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] data,
  output logic          valid,
  output logic          irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data  <= '0;
      valid <= 1'b0;
      irq   <= 1'b0;
    end else begin
      irq <= wr;
      if (wr) begin
        data  <= wr_data;
        valid <= 1'b1;
      end else if (rd) begin
        valid <= 1'b0;
      end
    end
  end

  // R2/R3: an interrupt is always accompanied by fresh valid data
  a_r2_irq_has_data: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> valid);
  // R11: a read without a concurrent write leaves the register empty
  a_r11_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !wr) |=> !valid);
endmodule

// File: rtl/adcb_hold.sv
module adcb_hold #(
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          load,
  input  logic          load_inj,
  input  logic [DW-1:0] load_data,
  input  logic          drain,
  output logic          full,
  output logic          is_inj,
  output logic [DW-1:0] data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full   <= 1'b0;
      is_inj <= 1'b0;
      data   <= '0;
    end else if (flush) begin
      full <= 1'b0;
    end else if (load) begin
      full   <= 1'b1;
      is_inj <= load_inj;
      data   <= load_data;
    end else if (drain) begin
      full <= 1'b0;
    end
  end

  // R5: an occupied slot is never overwritten unless it empties that cycle
  a_r5_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !drain && !flush) |-> !load);
  // R9: a flush always empties the slot
  a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !full);
endmodule

// File: rtl/adcb_inj_gate.sv
module adcb_inj_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic req,
  input  logic blocked,
  output logic start
);
  logic pend;
  logic fire;

  assign fire = pend && enable && !blocked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend  <= 1'b0;
      start <= 1'b0;
    end else begin
      start <= fire;
      if (!enable)      pend <= 1'b0;
      else if (req)     pend <= 1'b1;
      else if (fire)    pend <= 1'b0;
    end
  end

  // R10: a start never issues out of a suspended or disabled cycle
  a_r10_start_gated: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> ($past(enable) && !$past(blocked)));
endmodule

// File: rtl/adc_result_buffer.sv
module adc_result_buffer #(
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold_mode,
  input  logic          cnv_done,
  input  logic          cnv_inj,
  input  logic [DW-1:0] cnv_data,
  input  logic          inj_req,
  input  logic          rd_std,
  input  logic          rd_inj,
  output logic [DW-1:0] std_data,
  output logic          std_valid,
  output logic          std_irq,
  output logic [DW-1:0] inj_data,
  output logic          inj_valid,
  output logic          inj_irq,
  output logic          suspend,
  output logic          inj_start
);
  import adcb_pkg::*;

  logic          h_full, h_inj;
  logic [DW-1:0] h_data;

  // Named internal events
  logic drain, drain_std, drain_inj;
  logic accept, direct_std, direct_inj, to_hold;
  logic wr_std, wr_inj;
  logic [DW-1:0] wr_std_data, wr_inj_data;

  always_comb begin
    drain     = hold_mode && hold_drains(h_full, h_inj, rd_std, rd_inj);
    drain_std = drain && !h_inj;
    drain_inj = drain && h_inj;
    // injected results exist only in hold-for-read mode
    accept    = cnv_done && (!cnv_inj || hold_mode);
    direct_std = accept && !cnv_inj &&
                 (!hold_mode || (slot_free(std_valid, rd_std) && !drain_std));
    direct_inj = accept && cnv_inj &&
                 slot_free(inj_valid, rd_inj) && !drain_inj;
    to_hold   = accept && hold_mode && !direct_std && !direct_inj &&
                (!h_full || drain);
    wr_std      = drain_std || direct_std;
    wr_inj      = drain_inj || direct_inj;
    wr_std_data = drain_std ? h_data : cnv_data;
    wr_inj_data = drain_inj ? h_data : cnv_data;
  end

  adcb_slot #(.DW(DW)) u_std (
    .clk(clk), .rst_n(rst_n), .rd(rd_std), .wr(wr_std), .wr_data(wr_std_data),
    .data(std_data), .valid(std_valid), .irq(std_irq));

  adcb_slot #(.DW(DW)) u_inj (
    .clk(clk), .rst_n(rst_n), .rd(rd_inj), .wr(wr_inj), .wr_data(wr_inj_data),
    .data(inj_data), .valid(inj_valid), .irq(inj_irq));

  adcb_hold #(.DW(DW)) u_hold (
    .clk(clk), .rst_n(rst_n), .flush(!hold_mode), .load(to_hold),
    .load_inj(cnv_inj), .load_data(cnv_data), .drain(drain),
    .full(h_full), .is_inj(h_inj), .data(h_data));

  assign suspend = h_full;

  adcb_inj_gate u_gate (
    .clk(clk), .rst_n(rst_n), .enable(hold_mode), .req(inj_req),
    .blocked(h_full), .start(inj_start));

  // R6: a read that releases a parked injected result re-raises its interrupt
  a_r6_reraise_inj: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_mode && suspend && h_inj && rd_inj) |=> (inj_irq && inj_valid));
  // R7: same for ordinary results
  a_r7_reraise_std: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_mode && suspend && !h_inj && rd_std) |=> (std_irq && std_valid));
  // R4: no injection interrupt while hold-for-read is off
  a_r4_no_inj_irq: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_mode |=> !inj_irq);
  // R9: disabling hold-for-read releases a suspended engine
  a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_mode |=> !suspend);
  // R5: parking a result raises no interrupt
  a_r5_park_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (to_hold && !drain) |=> (!std_irq && !inj_irq && suspend));
endmodule

// File: tb/tb_adc_result_buffer.sv
module tb_adc_result_buffer;
  localparam int DW = 12;
  logic clk = 1'b0, rst_n = 1'b0;
  logic hold_mode = 1'b0, cnv_done = 1'b0, cnv_inj = 1'b0, inj_req = 1'b0;
  logic rd_std = 1'b0, rd_inj = 1'b0;
  logic [DW-1:0] cnv_data = '0;
  logic [DW-1:0] std_data, inj_data;
  logic std_valid, std_irq, inj_valid, inj_irq, suspend, inj_start;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  adc_result_buffer #(.DW(DW)) dut (.*);

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // One cycle of stimulus applied at a falling edge, sampled at the next one.
  task automatic cyc(input logic d, input logic inj, input int data,
                     input logic rs, input logic ri, input logic ir);
    cnv_done = d; cnv_inj = inj; cnv_data = DW'(data);
    rd_std = rs; rd_inj = ri; inj_req = ir;
    @(negedge clk);
    cnv_done = 0; cnv_inj = 0; rd_std = 0; rd_inj = 0; inj_req = 0;
  endtask

  task automatic idle(); cyc(0, 0, 0, 0, 0, 0); endtask

  task automatic t_reset();
    chk("R1", "std_valid", std_valid, 0); chk("R1", "inj_valid", inj_valid, 0);
    chk("R1", "std_irq", std_irq, 0);     chk("R1", "inj_irq", inj_irq, 0);
    chk("R1", "std_data", std_data, 0);   chk("R1", "inj_data", inj_data, 0);
    chk("R1", "suspend", suspend, 0);     chk("R1", "inj_start", inj_start, 0);
  endtask

  task automatic t_std();
    cyc(1, 0, 'h111, 0, 0, 0);
    chk("R2", "std_data", std_data, 'h111); chk("R2", "std_irq", std_irq, 1);
    chk("R2", "std_valid", std_valid, 1);   chk("R2", "suspend", suspend, 0);
    idle(); chk("R2", "irq width", std_irq, 0);
    cyc(0, 0, 0, 1, 0, 0); chk("R11", "std_valid after read", std_valid, 0);
  endtask

  task automatic t_inj();
    cyc(1, 1, 'h222, 0, 0, 0);
    chk("R3", "inj_data", inj_data, 'h222); chk("R3", "inj_irq", inj_irq, 1);
    chk("R3", "inj_valid", inj_valid, 1);   chk("R3", "std_data kept", std_data, 'h111);
    chk("R3", "std_irq", std_irq, 0);
  endtask

  task automatic t_hold_inj();
    cyc(1, 1, 'h333, 0, 0, 0);
    chk("R5", "suspend", suspend, 1); chk("R5", "inj_irq", inj_irq, 0);
    chk("R5", "inj_data kept", inj_data, 'h222);
    cyc(0, 0, 0, 0, 1, 0);
    chk("R6", "inj_data moved", inj_data, 'h333); chk("R6", "inj_irq", inj_irq, 1);
    chk("R6", "inj_valid", inj_valid, 1);         chk("R6", "suspend", suspend, 0);
    cyc(0, 0, 0, 0, 1, 0);
    chk("R11", "inj_valid", inj_valid, 0); chk("R6", "no extra irq", inj_irq, 0);
  endtask

  task automatic t_hold_std();
    cyc(1, 0, 'h444, 0, 0, 0);
    cyc(1, 0, 'h555, 0, 0, 0);
    chk("R5", "std suspend", suspend, 1); chk("R5", "std kept", std_data, 'h444);
    chk("R5", "std_irq", std_irq, 0);
    cyc(0, 0, 0, 1, 0, 0);
    chk("R7", "std_data moved", std_data, 'h555); chk("R7", "std_irq", std_irq, 1);
    chk("R7", "suspend", suspend, 0);
    cyc(0, 0, 0, 1, 0, 0); chk("R11", "std_valid", std_valid, 0);
  endtask

  task automatic t_bypass();
    cyc(1, 0, 'h666, 0, 0, 0);
    cyc(1, 0, 'h777, 1, 0, 0);
    chk("R8", "std_data", std_data, 'h777); chk("R8", "std_irq", std_irq, 1);
    chk("R8", "suspend", suspend, 0);       chk("R8", "std_valid", std_valid, 1);
    cyc(0, 0, 0, 1, 0, 0);
  endtask

  task automatic t_release();
    cyc(1, 1, 'h888, 0, 0, 0);
    cyc(1, 1, 'h999, 0, 0, 0);
    chk("R9", "suspended", suspend, 1);
    hold_mode = 0; idle();
    chk("R9", "suspend released", suspend, 0);
    hold_mode = 1;
    cyc(0, 0, 0, 0, 1, 0);
    chk("R9", "parked discarded irq", inj_irq, 0);
    chk("R9", "inj_data", inj_data, 'h888);
  endtask

  task automatic t_no_hold();
    hold_mode = 0;
    cyc(1, 1, 'hAAA, 0, 0, 0);
    chk("R4", "inj_irq", inj_irq, 0); chk("R4", "inj_data", inj_data, 'h888);
    cyc(1, 0, 'hB01, 0, 0, 0);
    cyc(1, 0, 'hB02, 0, 0, 0);
    chk("R12", "std overwrite", std_data, 'hB02); chk("R12", "std_irq", std_irq, 1);
    chk("R12", "suspend", suspend, 0);
    hold_mode = 1;
    cyc(0, 0, 0, 1, 0, 0);
  endtask

  task automatic t_inj_req();
    cyc(0, 0, 0, 0, 0, 1);
    chk("R10", "start not yet", inj_start, 0);
    idle(); chk("R10", "start", inj_start, 1);
    idle(); chk("R10", "start width", inj_start, 0);
    cyc(1, 1, 'hC01, 0, 0, 0);
    cyc(1, 1, 'hC02, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 1);
    idle(); chk("R10", "held while suspended", inj_start, 0);
    cyc(0, 0, 0, 0, 1, 0); chk("R10", "still held at release", inj_start, 0);
    idle(); chk("R10", "start after release", inj_start, 1);
    cyc(0, 0, 0, 0, 1, 0);
    hold_mode = 0;
    cyc(0, 0, 0, 0, 0, 1);
    idle(); chk("R10", "dropped when off", inj_start, 0);
    idle(); chk("R10", "dropped later", inj_start, 0);
    hold_mode = 1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1; hold_mode = 1;
    @(negedge clk);
    t_std(); t_inj(); t_hold_inj(); t_hold_std(); t_bypass();
    t_release(); t_no_hold(); t_inj_req();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #100000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule